// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation miss by walking a two-level table in memory. When a miss arrives with its virtual address, it reads one word from the first-level table. That table has one entry for each 1 MB of virtual space, and its base address comes from a configuration input. Some first-level entries describe a 1 MB or 16 MB region completely. For those the walk ends after a single read. Other entries point to a second-level table of 256 words. For those a second read resolves a 4 KB or 64 KB page.

The walk ends in one of two ways. A successful walk produces a one-cycle fill record: the translated physical address of the missing virtual address and a region size code, ready to be written into the translation buffer. A failed walk produces a one-cycle fault with a cause code. A fault is raised when walking is switched off or when an entry at either level is absent.

The memory port is a plain request/valid pair. The block pulses a request for one cycle with a word address, then waits as long as needed for a response strobe. Only one walk is in flight at a time.

Top module: `tbl_walker`

## Requirements
- R1: If `walkEn` is low when a miss is accepted, `faultValid` rises in the next cycle with `faultCause` = 0, and no memory request is issued.
- R2: The first read goes to `tableBase` + VA[31:20]*4. Each request is a single-cycle `memReq` pulse. The block then waits any number of cycles for `memRspValid`.
- R3: A first-level entry whose bits 1:0 are 00 or 11 ends the walk with `faultCause` = 1 and no further read.
- R4: A first-level entry with bits 1:0 = 10 and bit 18 clear gives a fill with `fillSize` = 2 (1 MB) and `fillPa` = {entry[31:20], VA[19:0]}.
- R5: A first-level entry with bits 1:0 = 10 and bit 18 set gives a fill with `fillSize` = 3 (16 MB) and `fillPa` = {entry[31:24], VA[23:0]}.
- R6: A first-level entry with bits 1:0 = 01 causes a second read at {entry[31:10], 10'b0} + VA[19:12]*4.
- R7: A second-level entry with bits 1:0 = 00 ends the walk with `faultCause` = 2.
- R8: A second-level entry with bits 1:0 = 01 gives `fillSize` = 1 (64 KB) and `fillPa` = {entry[31:16], VA[15:0]}. Bits 1:0 of 10 or 11 give `fillSize` = 0 (4 KB) and `fillPa` = {entry[31:12], VA[11:0]}.
- R9: Every accepted miss yields exactly one single-cycle pulse on either `fillValid` or `faultValid`, never both. `busy` is high from the cycle after acceptance through the result cycle and low after it and out of reset.
- R10: `missValid` is ignored while `busy` is high: it starts no extra reads and does not change the result of the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| walkEn | input | 1 | Table walking enabled, sampled when a miss is accepted |
| tableBase | input | 32 | Byte address of the first-level table, sampled on acceptance |
| missValid | input | 1 | Miss request strobe, accepted while idle |
| missVa | input | 32 | Virtual address of the miss |
| busy | output | 1 | A walk is in progress |
| memReq | output | 1 | Single-cycle memory read request |
| memAddr | output | 32 | Byte address of the word to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data (table entry) |
| fillValid | output | 1 | Fill record valid for one cycle |
| fillPa | output | 32 | Translated physical address of the miss |
| fillSize | output | 2 | Region size: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB |
| faultValid | output | 1 | Translation fault for one cycle |
| faultCause | output | 2 | 0 = walking disabled, 1 = first level absent, 2 = second level absent |

## Verification
The bench walks every one of the 4096 first-level slots and all 256 second-level slots of one table. It varies the response latency so that the descriptor kinds and latencies land in different combinations. It puts junk in the entry bits that must be masked off. A design that keeps those bits, or that uses the wrong shift for one region size, returns a wrong physical address for exactly that kind of entry. Type 11 at the first level checks that it is treated as absent rather than as a block. A confused decode would return a fill where a fault with cause 1 is expected. Misses presented while disabled must fault without touching memory. A miss held high through a whole walk exposes a design that restarts itself or samples a fresh address.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
  parameter int ADDR_W   = 32;
  parameter int L1_IDX_W = 12;
  parameter int L2_IDX_W = 8;
  parameter int SUPER_BIT = 18;

  localparam int L1_SHIFT     = ADDR_W - L1_IDX_W;   // 1 MB granule
  localparam int L2_SHIFT     = L1_SHIFT - L2_IDX_W; // 4 KB granule
  localparam int L2_TBL_ALIGN = L2_IDX_W + 2;        // bytes per level-2 table, log2
  localparam int LARGE_SHIFT  = L2_SHIFT + 4;        // 64 KB
  localparam int SUPER_SHIFT  = L1_SHIFT + 4;        // 16 MB

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
  } walkState_t;

  typedef enum logic [1:0] {DESC_BAD, DESC_PTR, DESC_BLOCK} l1Desc_t;

  typedef enum logic [1:0] {SZ_4K = 2'd0, SZ_64K = 2'd1, SZ_1M = 2'd2, SZ_16M = 2'd3} regionSize_t;

  typedef enum logic [1:0] {CAUSE_OFF = 2'd0, CAUSE_L1 = 2'd1, CAUSE_L2 = 2'd2} faultCause_t;

  typedef struct packed {
    logic captureVa;
    logic loadL1;
    logic loadL2;
    logic selL2;
  } walkStb_t;
endpackage

// File: rtl/tw_dpath.sv
`timescale 1ns/1ps
module tw_dpath
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStb_t          stb,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [ADDR_W-1:0] missVa,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memAddr,
  output l1Desc_t           l1Desc,
  output logic              l2Ok,
  output logic [ADDR_W-1:0] fillPa,
  output regionSize_t       fillSize
);
  logic [ADDR_W-1:0] vaR, baseR, l1R, l2R;
  regionSize_t       sizeR;
  logic [ADDR_W-1:0] l1Addr, l2Base, l2Addr, offMask, frame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaR   <= '0;
      baseR <= '0;
      l1R   <= '0;
      l2R   <= '0;
      sizeR <= SZ_4K;
    end else begin
      if (stb.captureVa) begin
        vaR   <= missVa;
        baseR <= tableBase;
      end
      if (stb.loadL1) begin
        l1R   <= memRspData;
        sizeR <= memRspData[SUPER_BIT] ? SZ_16M : SZ_1M;
      end
      if (stb.loadL2) begin
        l2R   <= memRspData;
        sizeR <= (memRspData[1:0] == 2'b01) ? SZ_64K : SZ_4K;
      end
    end
  end

  // entry addresses: base plus index scaled to words
  assign l1Addr  = baseR + {{(ADDR_W-L1_IDX_W-2){1'b0}}, vaR[ADDR_W-1:L1_SHIFT], 2'b00};
  assign l2Base  = {l1R[ADDR_W-1:L2_TBL_ALIGN], {L2_TBL_ALIGN{1'b0}}};
  assign l2Addr  = l2Base + {{(ADDR_W-L2_IDX_W-2){1'b0}}, vaR[L1_SHIFT-1:L2_SHIFT], 2'b00};
  assign memAddr = stb.selL2 ? l2Addr : l1Addr;

  always_comb begin
    unique case (memRspData[1:0])
      2'b01:   l1Desc = DESC_PTR;
      2'b10:   l1Desc = DESC_BLOCK;
      default: l1Desc = DESC_BAD;
    endcase
  end
  assign l2Ok = |memRspData[1:0];

  always_comb begin
    unique case (sizeR)
      SZ_4K:   begin offMask = ADDR_W'((64'd1 << L2_SHIFT) - 64'd1);    frame = l2R; end
      SZ_64K:  begin offMask = ADDR_W'((64'd1 << LARGE_SHIFT) - 64'd1); frame = l2R; end
      SZ_1M:   begin offMask = ADDR_W'((64'd1 << L1_SHIFT) - 64'd1);    frame = l1R; end
      default: begin offMask = ADDR_W'((64'd1 << SUPER_SHIFT) - 64'd1); frame = l1R; end
    endcase
  end
  assign fillPa   = (frame & ~offMask) | (vaR & offMask);
  assign fillSize = sizeR;
endmodule

// File: rtl/tw_ctrl.sv
`timescale 1ns/1ps
module tw_ctrl
  import tw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        walkEn,
  input  logic        missValid,
  input  logic        memRspValid,
  input  l1Desc_t     l1Desc,
  input  logic        l2Ok,
  output walkStb_t    stb,
  output logic        busy,
  output logic        memReq,
  output logic        fillValid,
  output logic        faultValid,
  output faultCause_t faultCause
);
  walkState_t  state, stateNext;
  faultCause_t causeR, causeNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      causeR <= CAUSE_OFF;
    end else begin
      state  <= stateNext;
      causeR <= causeNext;
    end
  end

  always_comb begin
    stateNext = state;
    causeNext = causeR;
    stb       = '0;
    memReq    = 1'b0;
    unique case (state)
      ST_IDLE: if (missValid) begin
        stb.captureVa = 1'b1;
        if (walkEn) stateNext = ST_L1_REQ;
        else begin
          stateNext = ST_FAULT;
          causeNext = CAUSE_OFF;
        end
      end
      ST_L1_REQ: begin
        memReq    = 1'b1;
        stateNext = ST_L1_WAIT;
      end
      ST_L1_WAIT: if (memRspValid) begin
        unique case (l1Desc)
          DESC_BLOCK: begin stb.loadL1 = 1'b1; stateNext = ST_DONE; end
          DESC_PTR:   begin stb.loadL1 = 1'b1; stateNext = ST_L2_REQ; end
          default:    begin stateNext = ST_FAULT; causeNext = CAUSE_L1; end
        endcase
      end
      ST_L2_REQ: begin
        memReq    = 1'b1;
        stb.selL2 = 1'b1;
        stateNext = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        stb.selL2 = 1'b1;
        if (memRspValid) begin
          if (l2Ok) begin
            stb.loadL2 = 1'b1;
            stateNext  = ST_DONE;
          end else begin
            stateNext = ST_FAULT;
            causeNext = CAUSE_L2;
          end
        end
      end
      default: stateNext = ST_IDLE;  // DONE and FAULT last one cycle
    endcase
  end

  assign busy       = (state != ST_IDLE);
  assign fillValid  = (state == ST_DONE);
  assign faultValid = (state == ST_FAULT);
  assign faultCause = causeR;

  // R1
  off_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && missValid && !walkEn) |=> (faultValid && faultCause == CAUSE_OFF));

  // R2
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R3
  l1_absent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_L1_WAIT && memRspValid && l1Desc == DESC_BAD) |=> (faultValid && faultCause == CAUSE_L1));

  // R9
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fillValid, faultValid}));

  // R9
  idle_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid || faultValid) |=> !busy);
endmodule

// File: rtl/tbl_walker.sv
`timescale 1ns/1ps
module tbl_walker
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              walkEn,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missVa,
  output logic              busy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillPa,
  output logic [1:0]        fillSize,
  output logic              faultValid,
  output logic [1:0]        faultCause
);
  walkStb_t    stb;
  l1Desc_t     l1Desc;
  logic        l2Ok;
  regionSize_t sizeE;
  faultCause_t causeE;

  tw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .walkEn(walkEn), .missValid(missValid),
    .memRspValid(memRspValid), .l1Desc(l1Desc), .l2Ok(l2Ok), .stb(stb),
    .busy(busy), .memReq(memReq), .fillValid(fillValid),
    .faultValid(faultValid), .faultCause(causeE)
  );

  tw_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .tableBase(tableBase), .missVa(missVa),
    .memRspData(memRspData), .memAddr(memAddr), .l1Desc(l1Desc), .l2Ok(l2Ok),
    .fillPa(fillPa), .fillSize(sizeE)
  );

  assign fillSize   = sizeE;
  assign faultCause = causeE;

  // R2
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));
endmodule

// File: tb/sim_tbl_walker.sv
`timescale 1ns/1ps
module sim_tbl_walker;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rstN, walkEn, missValid, memRspValid;
  logic [31:0] tableBase, missVa, memRspData, memAddr, fillPa;
  logic        busy, memReq, fillValid, faultValid;
  logic [1:0]  fillSize, faultCause;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tbl_walker u0 (
    .clk(clk), .rstN(rstN), .walkEn(walkEn), .tableBase(tableBase),
    .missValid(missValid), .missVa(missVa), .busy(busy), .memReq(memReq),
    .memAddr(memAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .fillValid(fillValid), .fillPa(fillPa), .fillSize(fillSize),
    .faultValid(faultValid), .faultCause(faultCause)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // table contents, computed from the address
  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [31:0] i, j, d;
    if (!a[31]) begin
      i = (a - BASE) >> 2;
      case (i % 5)
        0: d = (i * 3) << 2;                                          // 00 absent
        1: d = 32'h8000_0000 | (i << 10) | (32'hA5 << 2) | 32'd1;     // pointer
        2: d = (((i ^ 32'h5A3) & 32'hFFF) << 20) | 32'h0000_3AC8 | 32'd2; // 1 MB
        3: d = ((i & 32'hFF) << 24) | (32'd1 << 18) | 32'h0012_3450 | 32'd2; // 16 MB
        default: d = (i << 20) | 32'h0000_0F00 | 32'd3;               // 11 absent
      endcase
    end else begin
      i = (a >> 10) & 32'hFFF;
      j = (a >> 2) & 32'hFF;
      case (j % 4)
        0: d = (j << 8) | 32'h0000_0050;
        1: d = ((i * 7 + j) << 16) | 32'h0000_F0F0 | 32'd1;
        2: d = ((i * 256 + j + 5) << 12) | 32'h0000_0A5C | 32'd2;
        default: d = ((~(i * 256 + j)) << 12) | 32'd3;
      endcase
    end
    return d;
  endfunction

  task automatic expectFor(input logic [31:0] va, input bit en, output bit isFault,
                           output logic [1:0] cause, output logic [1:0] size,
                           output logic [31:0] pa, output int nReads,
                           output logic [31:0] a1, output logic [31:0] a2, output string tag);
    logic [31:0] e1, e2;
    isFault = 0; cause = 0; size = 0; pa = 0; a2 = 0;
    a1 = BASE + ((va >> 20) << 2);
    if (!en) begin
      isFault = 1; cause = 0; nReads = 0; tag = "R1"; return;
    end
    e1 = memWord(a1);
    nReads = 1;
    case (e1[1:0])
      2'b10: if (e1[18]) begin size = 3; pa = {e1[31:24], va[23:0]}; tag = "R5"; end
             else        begin size = 2; pa = {e1[31:20], va[19:0]}; tag = "R4"; end
      2'b01: begin
        nReads = 2;
        a2 = {e1[31:10], 10'b0} + {22'b0, va[19:12], 2'b00};
        e2 = memWord(a2);
        if (e2[1:0] == 2'b00) begin isFault = 1; cause = 2; tag = "R7"; end
        else if (e2[1:0] == 2'b01) begin size = 1; pa = {e2[31:16], va[15:0]}; tag = "R8"; end
        else begin size = 0; pa = {e2[31:12], va[11:0]}; tag = "R8"; end
      end
      default: begin isFault = 1; cause = 1; tag = "R3"; end
    endcase
  endtask

  task automatic runWalk(input logic [31:0] va, input bit en, input int lat, input bit holdOther);
    bit xFault, gFault, got, busyBad, pend;
    logic [1:0] xCause, xSize;
    logic [31:0] xPa, xA1, xA2, pAddr;
    logic [31:0] ra [2];
    int xReads, reads, dly;
    string tag;
    logic [35:0] gotRes, expRes;
    expectFor(va, en, xFault, xCause, xSize, xPa, xReads, xA1, xA2, tag);
    if (holdOther) tag = "R10";
    @(negedge clk);
    missVa = va; walkEn = en; missValid = 1'b1;
    @(negedge clk);
    if (holdOther) missVa = ~va; else missValid = 1'b0;
    walkEn = 1'b1;
    reads = 0; pend = 0; dly = 0; got = 0; busyBad = 0; gFault = 0;
    ra[0] = '0; ra[1] = '0; gotRes = '0;
    for (int c = 0; c < 40; c++) begin
      if (!busy) busyBad = 1;
      if (fillValid || faultValid) begin
        got = 1;
        gFault = faultValid;
        gotRes = faultValid ? {1'b1, 1'b0, faultCause, 32'h0} : {1'b0, 1'b0, fillSize, fillPa};
        break;
      end
      memRspValid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          memRspValid = 1'b1; memRspData = memWord(pAddr); pend = 0;
        end else dly--;
      end
      if (memReq) begin
        if (reads < 2) ra[reads] = memAddr;
        reads++; pAddr = memAddr; pend = 1; dly = lat;
      end
      @(negedge clk);
    end
    missValid = 1'b0;
    memRspValid = 1'b0;
    expRes = xFault ? {1'b1, 1'b0, xCause, 32'h0} : {1'b0, 1'b0, xSize, xPa};
    chk(got, "R9 result present", {63'b0, got}, 64'd1);
    chk(got && gotRes == expRes && gFault == xFault, tag, {28'b0, gotRes}, {28'b0, expRes});
    chk(reads == xReads, holdOther ? "R10 read count" : "R2 read count", reads, xReads);
    if (xReads >= 1) chk(ra[0] == xA1, "R2 first address", ra[0], xA1);
    if (xReads == 2) chk(ra[1] == xA2, "R6 second address", ra[1], xA2);
    chk(!busyBad, "R9 busy during walk", {63'b0, busyBad}, 64'd0);
    @(negedge clk);
    chk(!busy && !fillValid && !faultValid && !memReq, "R9 idle after result",
        {60'b0, busy, fillValid, faultValid, memReq}, 64'd0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; walkEn = 1'b1; missValid = 1'b0; missVa = '0;
    memRspValid = 1'b0; memRspData = '0; tableBase = BASE;
    repeat (3) @(negedge clk);
    chk(!busy && !memReq && !fillValid && !faultValid, "R9 reset state",
        {60'b0, busy, memReq, fillValid, faultValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memReq, "R9 idle after reset", {62'b0, busy, memReq}, 64'd0);

    // walking disabled: fault without reads
    for (int k = 0; k < 8; k++)
      runWalk(32'h1234_5678 * (k + 1), 1'b0, 0, k[0]);

    // every first-level slot, varied latency and offsets
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] va;
      va = {i[11:0], 8'(i * 37 + i / 5), 12'(i * 91)};
      runWalk(va, 1'b1, i % 4, (i % 7) == 3);
    end

    // every second-level slot behind one pointer entry
    for (int j = 0; j < 256; j++) begin
      logic [31:0] va;
      va = {12'd1, j[7:0], 12'(j * 17 + 3)};
      runWalk(va, 1'b1, j % 3, 1'b0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule